// File: doc/BRIEF.md
# Response Flit Serializer

This block sits at the target side of an on-chip network and turns response packets into a stream of 33-bit flits. Each response arrives one word per beat with its return source ID, transaction ID, packet ID, a 2-bit status code, a 32-bit data word and a last-word flag. The top bit of every flit marks the end of the packet. The 32 bits below it carry either a header or one data word.

The status code says what kind of response it is. Bit 1 set means a write, and bit 0 set means an error. A write response, including the reply a target gives to a broadcast command, leaves as a single header flit with end-of-packet set, and its data word is never sent. A read response of N words leaves as one header flit followed by N data flits. The flits are produced in the same cycle the input is presented, through a valid/ready handshake on both sides. Output back-pressure holds the input in place, so no flit is dropped or repeated.

Control is a two-state machine. `ST_HEAD` emits the header flit. `ST_BODY` emits data flits. The transitions are:
- `HEAD_STAY`: a write header is accepted, or the input is idle.
- `HEAD_TO_BODY`: a read header is accepted.
- `BODY_STAY`: a data word that is not the last one is accepted.
- `BODY_TO_HEAD`: the last data word is accepted.

Top module: `rsp_flit_serializer`

## Requirements
- R1: After reset, and whenever `rsp_valid` is low, `flit_valid` and `rsp_ready` are both low.
- R2: A header flit has the following layout:
  - bits 31:18 hold the return source ID;
  - bits 17:12 are zero;
  - bits 11:8 hold the status field: bits 11:10 are zero and bits 9:8 are the 2-bit status code;
  - bits 7:4 hold the transaction ID;
  - bits 3:0 hold the packet ID.
- R3: A response whose status bit 1 is set (10 = write OK, 11 = write error) produces exactly one flit with bit 32 set. Its input beat is consumed in the same cycle that flit is accepted. The `rsp_data` and `rsp_eop` inputs have no effect on that flit.
- R4: For a read response (status 00 = read OK, 01 = read error), the header flit has bit 32 clear and does not consume the input beat.
- R5: Each read data flit carries the word in bits 31:0. Bit 32 equals that beat's `rsp_eop`, so only the last word's flit ends the packet.
- R6: A read response of N words produces exactly N+1 accepted flits and consumes exactly N input beats.
- R7: While `flit_ready` is low, `rsp_ready` is low. With the source holding its beat, `flit_valid` stays high and `flit_data` stays stable. `rsp_ready` is high only in a cycle where a flit is accepted.
- R8: The flit after a packet's end-of-packet flit is the header of the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Response beat consumed |
| rsp_srcid | input | 14 | Return source ID |
| rsp_trdid | input | 4 | Return transaction ID |
| rsp_pktid | input | 4 | Return packet ID |
| rsp_error | input | 2 | Status code; bit 1 marks a write, bit 0 an error |
| rsp_data | input | 32 | Read data word |
| rsp_eop | input | 1 | Last word of the response |
| flit_valid | output | 1 | Flit valid |
| flit_ready | input | 1 | Flit accepted by the network |
| flit_data | output | 33 | Flit; bit 32 is end-of-packet |

## Verification
The hardest case to reach is back-pressure that lands on a read header. The same input beat must then stay unconsumed across several stalled cycles, and it must still yield both the header and its first data flit without repeating either one. A second hard case is a stall on the last data word followed at once by a write response, which checks the return from `ST_BODY` to `ST_HEAD`. The bench sweeps every status code, read lengths from one to six words, and three ready patterns (always ready, alternating, and one stall in three). The ready pattern is keyed to a running cycle count, so stalls fall on headers, middle words and last words alike. Write beats carry all-ones data and a low last-word flag to show that both are ignored.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [0:0] {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } rfs_state_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_HEAD = 2'd1,
        FK_DATA = 2'd2
    } rfs_kind_e;
endpackage

// File: rtl/rfs_head_pack.sv
module rfs_head_pack #(
    parameter int DATA_W   = 32,
    parameter int SRCID_W  = 14,
    parameter int TRDID_W  = 4,
    parameter int PKTID_W  = 4,
    parameter int ERR_W    = 2,
    parameter int ERRF_W   = 4
) (
    input  logic [SRCID_W-1:0] srcid,
    input  logic [TRDID_W-1:0] trdid,
    input  logic [PKTID_W-1:0] pktid,
    input  logic [ERR_W-1:0]   err,
    output logic [DATA_W-1:0]  head_word
);
    localparam int RSV_W = DATA_W - SRCID_W - ERRF_W - TRDID_W - PKTID_W;
    localparam int PAD_W = ERRF_W - ERR_W;

    generate
        if (RSV_W < 1 || PAD_W < 1) begin : g_bad_cfg
            $error("header fields do not fit the data width");
        end
    endgenerate

    always_comb begin
        head_word = {srcid, {RSV_W{1'b0}}, {PAD_W{1'b0}}, err, trdid, pktid};
    end
endmodule

// File: rtl/rfs_ctrl.sv
module rfs_ctrl
    import rfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rsp_valid,
    input  logic      is_write,
    input  logic      rsp_eop,
    input  logic      flit_ready,
    output logic      rsp_ready,
    output logic      flit_valid,
    output logic      head_last,
    output rfs_kind_e kind
);
    rfs_state_e state_q, state_d;
    logic       fire;

    assign fire = rsp_valid && flit_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HEAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEAD: if (fire && !is_write) state_d = ST_BODY;  // HEAD_TO_BODY
            ST_BODY: if (fire && rsp_eop)   state_d = ST_HEAD;  // BODY_TO_HEAD
            default: state_d = ST_HEAD;
        endcase
    end

    always_comb begin
        flit_valid = rsp_valid;
        rsp_ready  = 1'b0;
        head_last  = 1'b0;
        kind       = FK_NONE;
        unique case (state_q)
            ST_HEAD: begin
                kind      = rsp_valid ? FK_HEAD : FK_NONE;
                head_last = is_write;
                rsp_ready = fire && is_write;
            end
            ST_BODY: begin
                kind      = rsp_valid ? FK_DATA : FK_NONE;
                rsp_ready = fire;
            end
            default: begin
                kind       = FK_NONE;
                flit_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rfs_flit_mux.sv
module rfs_flit_mux
    import rfs_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int FLIT_W = DATA_W + 1
) (
    input  rfs_kind_e         kind,
    input  logic [DATA_W-1:0] head_word,
    input  logic              head_last,
    input  logic [DATA_W-1:0] data_word,
    input  logic              data_last,
    output logic [FLIT_W-1:0] flit
);
    always_comb begin
        unique case (kind)
            FK_HEAD: flit = {head_last, head_word};
            FK_DATA: flit = {data_last, data_word};
            default: flit = '0;
        endcase
    end
endmodule

// File: rtl/rsp_flit_serializer.sv
module rsp_flit_serializer
    import rfs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SRCID_W = 14,
    parameter int TRDID_W = 4,
    parameter int PKTID_W = 4,
    parameter int ERR_W   = 2,
    parameter int ERRF_W  = 4,
    localparam int FLIT_W = DATA_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [SRCID_W-1:0] rsp_srcid,
    input  logic [TRDID_W-1:0] rsp_trdid,
    input  logic [PKTID_W-1:0] rsp_pktid,
    input  logic [ERR_W-1:0]   rsp_error,
    input  logic [DATA_W-1:0]  rsp_data,
    input  logic               rsp_eop,
    output logic               flit_valid,
    input  logic               flit_ready,
    output logic [FLIT_W-1:0]  flit_data
);
    logic [DATA_W-1:0] head_word;
    logic              head_last;
    rfs_kind_e         kind;

    rfs_head_pack #(
        .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W),
        .PKTID_W(PKTID_W), .ERR_W(ERR_W), .ERRF_W(ERRF_W)
    ) i_head (
        .srcid(rsp_srcid), .trdid(rsp_trdid), .pktid(rsp_pktid),
        .err(rsp_error), .head_word(head_word)
    );

    rfs_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid),
        .is_write(rsp_error[ERR_W-1]), .rsp_eop(rsp_eop),
        .flit_ready(flit_ready), .rsp_ready(rsp_ready),
        .flit_valid(flit_valid), .head_last(head_last), .kind(kind)
    );

    rfs_flit_mux #(.DATA_W(DATA_W)) i_mux (
        .kind(kind), .head_word(head_word), .head_last(head_last),
        .data_word(rsp_data), .data_last(rsp_eop), .flit(flit_data)
    );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int DATA_W  = 32,
    parameter int SRCID_W = 14,
    parameter int TRDID_W = 4,
    parameter int PKTID_W = 4,
    parameter int ERR_W   = 2,
    parameter int ERRF_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [SRCID_W-1:0] rsp_srcid,
    input logic [ERR_W-1:0]   rsp_error,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               rsp_eop,
    input logic               flit_valid,
    input logic               flit_ready,
    input logic [DATA_W:0]    flit_data
);
    localparam int ERR_LO = TRDID_W + PKTID_W;
    logic in_body;
    logic fire;
    assign fire = flit_valid && flit_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    in_body <= 1'b0;
        else if (fire) in_body <= !flit_data[DATA_W];
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!flit_valid && !rsp_ready));
    // R7
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (flit_valid && flit_ready));
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_ready && rsp_valid) |=> (!rsp_valid || (flit_valid && $stable(flit_data))));
    // R3
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_body && fire && rsp_error[ERR_W-1]) |-> (flit_data[DATA_W] && rsp_ready));
    // R4
    read_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_body && fire && !rsp_error[ERR_W-1]) |-> (!flit_data[DATA_W] && !rsp_ready));
    // R2
    head_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_body && flit_valid) |->
        (flit_data[DATA_W-1 -: SRCID_W] == rsp_srcid &&
         flit_data[ERR_LO +: ERRF_W] == {{(ERRF_W-ERR_W){1'b0}}, rsp_error}));
    // R5
    body_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_body && flit_valid) |-> (flit_data == {rsp_eop, rsp_data}));
endmodule

bind rsp_flit_serializer rfs_checker #(
    .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W),
    .PKTID_W(PKTID_W), .ERR_W(ERR_W), .ERRF_W(ERRF_W)
) i_rfs_checker (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_srcid(rsp_srcid), .rsp_error(rsp_error), .rsp_data(rsp_data),
    .rsp_eop(rsp_eop), .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data)
);

// File: tb/test_rsp_flit_serializer.sv
`timescale 1ns/1ps
module test_rsp_flit_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [13:0] rsp_srcid = '0;
    logic [3:0]  rsp_trdid = '0;
    logic [3:0]  rsp_pktid = '0;
    logic [1:0]  rsp_error = '0;
    logic [31:0] rsp_data = '0;
    logic        rsp_eop = 1'b0;
    logic        flit_valid;
    logic        flit_ready = 1'b0;
    logic [32:0] flit_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rsp_flit_serializer i_rsp_flit_serializer (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_srcid(rsp_srcid), .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid),
        .rsp_error(rsp_error), .rsp_data(rsp_data), .rsp_eop(rsp_eop),
        .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data)
    );

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int r, input int k);
        return 32'h1000_0000 * (k + 1) + 32'h0001_0101 * r + k;
    endfunction

    function automatic logic rdy_of(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return c[0];
            default: return (c % 3) != 0;
        endcase
    endfunction

    task automatic send(input int r, input logic [1:0] err, input int nw, input int mode);
        logic [32:0] exp [0:7];
        int nexp, fi, beat, flits;
        logic wr;
        logic [13:0] sid;
        wr  = err[1];
        sid = 14'h2A5A ^ 14'(r * 37);
        nexp = wr ? 1 : nw + 1;
        exp[0] = {wr, sid, 6'b0, 2'b0, err, 4'(r), 4'(r * 3)};
        for (int k = 0; k < nw; k++) exp[k + 1] = {k == nw - 1, word_of(r, k)};
        fi = 0; beat = 0; flits = 0;
        while (fi < nexp) begin
            @(negedge clk);
            rsp_valid  = 1'b1;
            rsp_srcid  = sid;
            rsp_trdid  = 4'(r);
            rsp_pktid  = 4'(r * 3);
            rsp_error  = err;
            rsp_data   = wr ? 32'hFFFF_FFFF : word_of(r, beat);
            rsp_eop    = wr ? 1'b0 : (beat == nw - 1);
            flit_ready = rdy_of(mode, cyc);
            cyc++;
            #1;
            chk("R7 flit_valid with beat held", {32'b0, flit_valid}, 33'd1);
            if (flit_ready) begin
                // R2 header layout, R3 write single flit, R5 data flits, R8 header after end
                chk(fi == 0 ? (wr ? "R3" : "R2") : "R5", flit_data, exp[fi]);
                chk(wr ? "R3 consume" : (fi == 0 ? "R4 header no consume" : "R5 consume"),
                    {32'b0, rsp_ready}, {32'b0, (wr || fi > 0)});
                if (rsp_ready) beat++;
                fi++;
                flits++;
            end else begin
                chk("R7 stall no consume", {32'b0, rsp_ready}, 33'd0);
            end
        end
        chk("R6 beats consumed", 33'(beat), wr ? 33'd1 : 33'(nw));
        chk("R6 flit count", 33'(flits), 33'(nexp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset valid", {32'b0, flit_valid}, 33'd0);
        chk("R1 reset ready", {32'b0, rsp_ready}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 idle", {31'b0, flit_valid, rsp_ready}, 33'd0);
        for (int m = 0; m < 3; m++)
            for (int e = 0; e < 4; e++)
                for (int n = 1; n <= 6; n++)
                    send(m * 40 + e * 8 + n, 2'(e), n, m);
        @(negedge clk);
        rsp_valid  = 1'b0;
        flit_ready = 1'b1;
        #1;
        chk("R1 idle after traffic", {31'b0, flit_valid, rsp_ready}, 33'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule